// File: doc/BRIEF.md
# Paced Sample FIFO Controller

This block schedules conversions on a sampling converter and collects their results for a DMA engine. A conversion can be requested once, or run continuously. In continuous mode the spacing between conversions comes from a fractional divider; when the divider is zero, a new conversion follows the previous one immediately. The converter is modelled as a handshake. The block raises a one-cycle start pulse with a channel number, and the converter later answers with a one-cycle done pulse and a 12-bit result.

Each result is written into a small FIFO. It can first be reduced to its upper eight bits. A data request line tells the DMA engine when enough samples are waiting. The channel select can rotate through a set of enabled inputs, so one continuous run can sample several inputs in turn. Sticky flags record samples lost to a full FIFO and reads from an empty one.

Top module: `sample_pacer`

## Requirements
- R1: After reset the block has the following state:
  - `ready` = 1
  - `convStart` = 0
  - `oneShotPending` = 0
  - `fifoLevel` = 0
  - `dataReq` = 0
  - `overflow` = 0
  - `underflow` = 0
  - the channel select = 0
- R2: A pulse on `startOnce` sets `oneShotPending` at the next edge. While `ready` = 1, a pending one-shot makes `convStart` high in that same cycle. `oneShotPending` clears at the edge where its conversion begins.
- R3: `ready` is 0 from the cycle after `convStart` until the cycle after the answering `convDone`. `convStart` is never high while `ready` = 0.
- R4: When `runMany` = 1 and both divider fields are zero, the next `convStart` comes in the cycle right after a conversion completes. With a converter latency of L cycles, starts are therefore L+1 cycles apart.
- R5: When `runMany` = 1 and the divider is non-zero, the first start comes in the cycle where `runMany` rises. Each later start comes 1 + `divInt` + c cycles after the one before. Here c is the carry out of an 8-bit accumulator that adds `divFrac` once per period, starting from zero. The mean period is therefore 1 + INT + FRAC/256. For example, INT = 9 and FRAC = 128 give periods of 10, 11, 10, 11, and so on.
- R6: A pulse on `divWrite` clears the divider count and the accumulator. The next paced start then comes in the cycle after the write.
- R7: Channel rotation:
  - `chanSelWrite` loads `chanSelIn` into the channel select.
  - While `chanMask` is non-zero, each completed conversion moves the select to the next set mask bit above the current channel, wrapping from 3 to 0.
  - A zero mask keeps the select fixed.
- R8: When `shiftEn` = 1, the FIFO stores result bits [11:4] in bits [7:0], with the upper bits zero. Otherwise it stores the full 12-bit result.
- R9: The FIFO returns results in arrival order. A `popReq` pulse places the oldest entry on `popData` at the following edge.
- R10: `dataReq` = 1 exactly when `reqEn` = 1 and `fifoLevel` >= `threshold`.
- R11: A result that arrives while the 4-entry FIFO is full is dropped and sets `overflow`. `overflow` stays set until `flagClear`.
- R12: A pop from an empty FIFO loads zero into `popData` and sets `underflow`. `underflow` stays set until `flagClear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startOnce | input | 1 | Request a single conversion (pulse) |
| runMany | input | 1 | Continuous conversion enable |
| divInt | input | 16 | Divider integer part |
| divFrac | input | 8 | Divider fractional part (1/256 units) |
| divWrite | input | 1 | Divider fields written; restart divider (pulse) |
| chanSelIn | input | 3 | Channel select load value |
| chanSelWrite | input | 1 | Load the channel select (pulse) |
| chanMask | input | 4 | Rotation mask, one bit per channel 0..3 |
| shiftEn | input | 1 | Store results reduced to 8 bits |
| reqEn | input | 1 | Data request enable |
| threshold | input | 4 | FIFO level that raises the data request |
| popReq | input | 1 | Read one FIFO entry (pulse) |
| flagClear | input | 1 | Clear the sticky flags (pulse) |
| convDone | input | 1 | Converter result valid (pulse) |
| convResult | input | 12 | Converter result |
| convStart | output | 1 | Start a conversion (pulse) |
| convChan | output | 3 | Channel for the conversion |
| ready | output | 1 | No conversion in flight |
| oneShotPending | output | 1 | A one-shot request is waiting |
| popData | output | 12 | Entry returned by the last pop |
| fifoLevel | output | 3 | Number of stored entries |
| dataReq | output | 1 | DMA request |
| overflow | output | 1 | Sticky: a result was dropped |
| underflow | output | 1 | Sticky: an empty FIFO was read |

## Verification
The bench measures the cycle gaps between starts for a fractional divider whose carry alternates every period. If the accumulator or its carry were wrong, the gaps would come out uniform or shifted by one.

It pulses `divWrite` partway through a long period and expects a start on the very next cycle. A divider that kept its count would instead wait out the rest of the period.

Rotation is checked with a sparse mask and with an empty mask. Skipping, repeating or advancing under a zero mask would change the recorded channel sequence.

The FIFO tests cover the full and empty edges. A fifth result must be dropped, leaving the four older entries in order. A pop from an empty FIFO must return zero and set the flag. The request line is checked at exactly the threshold level.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  // Strobes from the sequencing control into the datapath
  typedef struct packed {
    logic issue; // a conversion starts this cycle
    logic land;  // a conversion result arrives this cycle
  } pacerStrobe_t;
endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startOnce,
  input  logic              runMany,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              divWrite,
  input  logic              convDone,
  output pacerStrobe_t      strobe,
  output logic              busy,
  output logic              oneShotPend
);
  localparam int CNT_W = INT_W + 1;

  logic              busyQ, pendQ, tickPendQ;
  logic [CNT_W-1:0]  cntQ;
  logic [FRAC_W-1:0] accQ;
  logic [FRAC_W:0]   accSum;
  logic              divZero, tick, issue, land;

  assign divZero = (divInt == '0) && (divFrac == '0);
  // Paced tick: count has run out while continuous mode is on
  assign tick    = runMany && !divZero && (cntQ == '0);
  assign issue   = !busyQ && (pendQ || (runMany && (divZero || tick || tickPendQ)));
  assign land    = busyQ && convDone;
  assign accSum  = {1'b0, accQ} + {1'b0, divFrac};

  // Divider: period = 1 + divInt + carry of the fractional accumulator
  always_ff @(posedge clk) begin
    if (!rstN || divWrite || !runMany) begin
      cntQ      <= '0;
      accQ      <= '0;
      tickPendQ <= 1'b0;
    end else begin
      if (tick) begin
        accQ <= accSum[FRAC_W-1:0];
        cntQ <= CNT_W'(divInt) + CNT_W'(accSum[FRAC_W]);
      end else if (cntQ != '0) begin
        cntQ <= cntQ - 1'b1;
      end
      tickPendQ <= (tickPendQ || tick) && !issue;
    end
  end

  // Conversion in flight and one-shot request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (issue)     busyQ <= 1'b1;
      else if (land) busyQ <= 1'b0;
      pendQ <= (pendQ && !issue) || startOnce;
    end
  end

  assign strobe.issue = issue;
  assign strobe.land  = land;
  assign busy         = busyQ;
  assign oneShotPend  = pendQ;
endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int OUT_W  = 8,
  parameter int DEPTH  = 4,
  parameter int SEL_W  = 3,
  parameter int MASK_W = 4,
  parameter int THR_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pacerStrobe_t      strobe,
  input  logic [RES_W-1:0]  convResult,
  input  logic [SEL_W-1:0]  chanSelIn,
  input  logic              chanSelWrite,
  input  logic [MASK_W-1:0] chanMask,
  input  logic              shiftEn,
  input  logic              reqEn,
  input  logic [THR_W-1:0]  threshold,
  input  logic              popReq,
  input  logic              flagClear,
  output logic [SEL_W-1:0]  convChan,
  output logic [RES_W-1:0]  popData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              dataReq,
  output logic              overflow,
  output logic              underflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SHIFT = RES_W - OUT_W;

  logic [SEL_W-1:0] chanQ, chanNext;
  logic [RES_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] levelQ;
  logic [RES_W-1:0] packedRes;
  logic             isFull, isEmpty, doPush, doPop;

  // Next enabled channel above the current one, wrapping
  always_comb begin
    int base;
    int idx;
    logic found;
    chanNext = chanQ;
    found    = 1'b0;
    base     = int'(chanQ) % MASK_W;
    for (int k = 1; k <= MASK_W; k++) begin
      idx = (base + k) % MASK_W;
      if (!found && chanMask[idx]) begin
        chanNext = SEL_W'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  chanQ <= '0;
    else if (chanSelWrite)      chanQ <= chanSelIn;
    else if (strobe.land && chanMask != '0) chanQ <= chanNext;
  end

  assign packedRes = shiftEn ? (convResult >> SHIFT) : convResult;
  assign isFull    = (levelQ == LVL_W'(DEPTH));
  assign isEmpty   = (levelQ == '0);
  assign doPush    = strobe.land && !isFull;
  assign doPop     = popReq && !isEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= packedRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      levelQ    <= '0;
      popData   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      levelQ <= levelQ + LVL_W'(doPush) - LVL_W'(doPop);
      if (popReq) popData <= isEmpty ? '0 : mem[rdPtr];
      overflow  <= (overflow && !flagClear) || (strobe.land && isFull);
      underflow <= (underflow && !flagClear) || (popReq && isEmpty);
    end
  end

  assign convChan  = chanQ;
  assign fifoLevel = levelQ;
  assign dataReq   = reqEn && (int'(levelQ) >= int'(threshold));
endmodule

// File: rtl/sample_pacer.sv
module sample_pacer
  import pacer_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int OUT_W  = 8,
  parameter int DEPTH  = 4,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int SEL_W  = 3,
  parameter int MASK_W = 4,
  parameter int THR_W  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startOnce,
  input  logic              runMany,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              divWrite,
  input  logic [SEL_W-1:0]  chanSelIn,
  input  logic              chanSelWrite,
  input  logic [MASK_W-1:0] chanMask,
  input  logic              shiftEn,
  input  logic              reqEn,
  input  logic [THR_W-1:0]  threshold,
  input  logic              popReq,
  input  logic              flagClear,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              convStart,
  output logic [SEL_W-1:0]  convChan,
  output logic              ready,
  output logic              oneShotPending,
  output logic [RES_W-1:0]  popData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              dataReq,
  output logic              overflow,
  output logic              underflow
);
  pacerStrobe_t strobe;
  logic         busy;

  pacer_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) ctrl (
    .clk(clk), .rstN(rstN), .startOnce(startOnce), .runMany(runMany),
    .divInt(divInt), .divFrac(divFrac), .divWrite(divWrite),
    .convDone(convDone), .strobe(strobe), .busy(busy),
    .oneShotPend(oneShotPending)
  );

  pacer_datapath #(
    .RES_W(RES_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .SEL_W(SEL_W),
    .MASK_W(MASK_W), .THR_W(THR_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convResult(convResult),
    .chanSelIn(chanSelIn), .chanSelWrite(chanSelWrite), .chanMask(chanMask),
    .shiftEn(shiftEn), .reqEn(reqEn), .threshold(threshold),
    .popReq(popReq), .flagClear(flagClear), .convChan(convChan),
    .popData(popData), .fifoLevel(fifoLevel), .dataReq(dataReq),
    .overflow(overflow), .underflow(underflow)
  );

  assign convStart = strobe.issue;
  assign ready     = !busy;
endmodule

// File: rtl/sample_pacer_checks.sv
module sample_pacer_checks #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             convStart,
  input logic             convDone,
  input logic             ready,
  input logic             oneShotPending,
  input logic             popReq,
  input logic             flagClear,
  input logic             reqEn,
  input logic             dataReq,
  input logic             overflow,
  input logic             underflow,
  input logic [LVL_W-1:0] fifoLevel
);
  assert_start_blocks_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !ready);

  assert_pending_served_R2: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotPending && ready) |-> convStart);

  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flagClear) |=> overflow);

  assert_empty_pop_flags_R12: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fifoLevel == '0) |=> underflow);

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoLevel) <= DEPTH);

  assert_no_growth_without_result_R9: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> fifoLevel <= $past(fifoLevel));

  assert_request_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqEn |-> !dataReq);
endmodule

bind sample_pacer sample_pacer_checks #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
  .ready(ready), .oneShotPending(oneShotPending), .popReq(popReq),
  .flagClear(flagClear), .reqEn(reqEn), .dataReq(dataReq),
  .overflow(overflow), .underflow(underflow), .fifoLevel(fifoLevel)
);

// File: tb/sample_pacer_test.sv
module sample_pacer_test;
  localparam int LAT   = 3;
  localparam int DEPTH = 4;

  logic clk = 0;
  logic rstN = 0;
  logic startOnce = 0, runMany = 0, divWrite = 0, chanSelWrite = 0;
  logic [15:0] divInt = '0;
  logic [7:0]  divFrac = '0;
  logic [2:0]  chanSelIn = '0;
  logic [3:0]  chanMask = '0;
  logic shiftEn = 0, reqEn = 0, popReq = 0, flagClear = 0, convDone = 0;
  logic [3:0]  threshold = '0;
  logic [11:0] convResult = '0;
  logic convStart, ready, oneShotPending, dataReq, overflow, underflow;
  logic [2:0]  convChan;
  logic [11:0] popData;
  logic [2:0]  fifoLevel;

  sample_pacer uut (
    .clk(clk), .rstN(rstN), .startOnce(startOnce), .runMany(runMany),
    .divInt(divInt), .divFrac(divFrac), .divWrite(divWrite),
    .chanSelIn(chanSelIn), .chanSelWrite(chanSelWrite), .chanMask(chanMask),
    .shiftEn(shiftEn), .reqEn(reqEn), .threshold(threshold), .popReq(popReq),
    .flagClear(flagClear), .convDone(convDone), .convResult(convResult),
    .convStart(convStart), .convChan(convChan), .ready(ready),
    .oneShotPending(oneShotPending), .popData(popData), .fifoLevel(fifoLevel),
    .dataReq(dataReq), .overflow(overflow), .underflow(underflow)
  );

  always #4 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle++;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Scoreboard state
  int expQ[$];
  int benchLvl = 0;
  int startCycles[$];
  int startChans[$];
  int pendCnt = 0, seqNum = 0, curRes = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model and expected-result driver
  initial begin
    forever begin
      @(negedge clk); #1;
      convDone = 0;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          convDone   = 1;
          convResult = 12'(curRes);
          if (benchLvl < DEPTH) begin
            expQ.push_back(shiftEn ? (curRes >> 4) : curRes);
            benchLvl++;
          end
        end
      end
      if (convStart) begin
        startCycles.push_back(cycle);
        startChans.push_back(int'(convChan));
        curRes  = (seqNum * 419 + int'(convChan) * 273 + 90) & 12'hFFF;
        seqNum++;
        pendCnt = LAT;
      end
    end
  end

  // Monitor side: pop one entry and compare with the scoreboard head
  task automatic popCheck(string req);
    int exp;
    @(negedge clk) popReq = 1;
    @(negedge clk) popReq = 0;
    #2;
    if (benchLvl > 0) begin
      exp = expQ.pop_front();
      benchLvl--;
    end else begin
      exp = 0;
    end
    check(int'(popData) == exp, req, int'(popData), exp);
  endtask

  task automatic oneShot();
    @(negedge clk) startOnce = 1;
    @(negedge clk) startOnce = 0;
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic clearFlags();
    @(negedge clk) flagClear = 1;
    @(negedge clk) flagClear = 0;
  endtask

  task automatic drain(string req);
    while (benchLvl > 0) popCheck(req);
    clearFlags();
  endtask

  task automatic stopRun();
    @(negedge clk) runMany = 0;
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    int c0, cw;
    repeat (5) @(negedge clk);
    rstN = 1;
    #2;
    // R1 reset state
    check(ready == 1, "R1 ready", ready, 1);
    check(convStart == 0 && oneShotPending == 0, "R1 start idle", convStart, 0);
    check(fifoLevel == 0, "R1 level", fifoLevel, 0);
    check(dataReq == 0 && overflow == 0 && underflow == 0, "R1 flags",
          {dataReq, overflow, underflow}, 0);
    check(convChan == 0, "R1 channel", convChan, 0);

    // R2 / R3 one-shot handshake
    @(negedge clk) startOnce = 1;
    @(negedge clk) startOnce = 0;
    #2;
    check(oneShotPending == 1, "R2 pending set", oneShotPending, 1);
    check(convStart == 1, "R2 start while ready", convStart, 1);
    @(negedge clk); #2;
    check(oneShotPending == 0, "R2 pending cleared", oneShotPending, 0);
    check(ready == 0, "R3 busy after start", ready, 0);
    @(negedge clk); @(negedge clk); #2;
    check(ready == 0, "R3 busy until done", ready, 0);
    @(negedge clk); #2;
    check(ready == 1, "R3 ready after done", ready, 1);
    check(fifoLevel == 1, "R9 level one", fifoLevel, 1);
    popCheck("R9 single");

    // R10 threshold and R9 ordering
    reqEn = 1; threshold = 4'd3;
    oneShot(); oneShot(); #2;
    check(dataReq == 0, "R10 below threshold", dataReq, 0);
    oneShot(); #2;
    check(dataReq == 1, "R10 at threshold", dataReq, 1);
    @(negedge clk) reqEn = 0; #2;
    check(dataReq == 0, "R10 disabled", dataReq, 0);
    popCheck("R9 order"); popCheck("R9 order"); popCheck("R9 order");

    // R8 byte reduction
    shiftEn = 1;
    oneShot(); oneShot();
    popCheck("R8 shifted");
    #1;
    check(popData < 12'd256, "R8 upper bits zero", popData, 255);
    popCheck("R8 shifted");
    shiftEn = 0;

    // R11 overflow
    repeat (5) oneShot();
    #2;
    check(fifoLevel == 4, "R11 level full", fifoLevel, 4);
    check(overflow == 1, "R11 overflow set", overflow, 1);
    repeat (4) popCheck("R11 survivors");
    #2;
    check(overflow == 1, "R11 overflow sticky", overflow, 1);
    clearFlags(); #2;
    check(overflow == 0, "R11 overflow cleared", overflow, 0);

    // R12 underflow
    popCheck("R12 empty returns zero");
    check(underflow == 1, "R12 underflow set", underflow, 1);
    clearFlags(); #2;
    check(underflow == 0, "R12 underflow cleared", underflow, 0);

    // R4 back-to-back and R7 rotation over mask 1010 from channel 1
    @(negedge clk) begin chanSelIn = 3'd1; chanSelWrite = 1; chanMask = 4'b1010; end
    @(negedge clk) chanSelWrite = 0;
    #2;
    check(convChan == 1, "R7 select load", convChan, 1);
    startCycles.delete(); startChans.delete();
    @(negedge clk) runMany = 1;
    repeat (20) @(negedge clk);
    stopRun();
    for (int i = 1; i < 5; i++)
      check(startCycles[i] - startCycles[i-1] == LAT + 1, "R4 back-to-back gap",
            startCycles[i] - startCycles[i-1], LAT + 1);
    for (int i = 0; i < 4; i++)
      check(startChans[i] == ((i % 2 == 0) ? 1 : 3), "R7 rotation",
            startChans[i], (i % 2 == 0) ? 1 : 3);
    drain("R9 after run");

    // R7 zero mask holds channel
    @(negedge clk) begin chanSelIn = 3'd2; chanSelWrite = 1; chanMask = 4'b0000; end
    @(negedge clk) chanSelWrite = 0;
    startChans.delete();
    oneShot(); oneShot();
    check(startChans[0] == 2 && startChans[1] == 2, "R7 zero mask",
          startChans[1], 2);
    drain("R9 zero mask data");

    // R5 fractional pacing: INT=9, FRAC=128 gives 10,11,10,11
    divInt = 16'd9; divFrac = 8'd128;
    startCycles.delete();
    @(negedge clk) begin runMany = 1; c0 = cycle; end
    repeat (50) @(negedge clk);
    stopRun();
    check(startCycles[0] == c0, "R5 first start immediate", startCycles[0], c0);
    for (int i = 1; i < 5; i++)
      check(startCycles[i] - startCycles[i-1] == ((i % 2 == 1) ? 10 : 11),
            "R5 period", startCycles[i] - startCycles[i-1], (i % 2 == 1) ? 10 : 11);
    drain("R9 paced data");

    // R6 divider restart on write
    divInt = 16'd20; divFrac = 8'd0;
    startCycles.delete();
    @(negedge clk) runMany = 1;
    repeat (8) @(negedge clk);
    divWrite = 1; cw = cycle;
    @(negedge clk) divWrite = 0;
    repeat (4) @(negedge clk);
    stopRun();
    check(startCycles.size() >= 2 && startCycles[1] == cw + 1, "R6 restart",
          (startCycles.size() >= 2) ? startCycles[1] : -1, cw + 1);
    drain("R9 restart data");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule